// File: doc/BRIEF.md
# Multi-drop serial receiver with sleep and wake-up

This block receives asynchronous serial characters of 10 bits (start, 8 data, stop) or 11 bits (start, 9 data, stop) from a line sampled at 16 times the bit rate. The bit rate comes from an external `sample_tick` strobe, one pulse per oversampling slot. Data bits arrive least significant first. Each received word is placed in a data register. Five status flags accompany it: ready, idle, overrun, noise and framing error. A single `irq` output combines these flags under two enable bits.

On a bus shared by several receivers, software can put the receiver to sleep by setting a sleep bit. Frames keep being shifted in while the receiver sleeps, but they raise no flags. Hardware clears the sleep bit on one of two wake conditions, chosen by a mode bit. In idle-line mode the condition is a full character time of continuous high line. In address-mark mode the condition is a received word whose most significant bit is 1; that word is then delivered as normal data.

Software reaches the block through a plain strobe register port. Writes take effect at the clock edge. Reads are combinational from `reg_addr`. The port has no back-pressure: a strobe is always accepted in the cycle it is given. While the receiver is enabled, `rx_pin_input` asks the pad logic to hold the pin as an input.

Top module: `sleep_uart_rx`

## Requirements
- R1: After reset, and whenever the enable bit is 0, all five status flags read 0, received frames are discarded, and the control register resets to 0.
- R2: `rx_pin_input` equals the enable bit, updated in the cycle after a control write.
- R3: Control register (address 0) holds these bits: bit0 enable, bit1 sleep, bit2 wake mode (1 = address mark), bit3 nine-bit frames, bit4 receive interrupt enable, bit5 idle interrupt enable. Status register (address 1) holds these bits: bit0 ready, bit1 idle, bit2 overrun, bit3 noise, bit4 framing error. Data register (address 2) returns the word, LSB first on the line, with bit 8 forced to 0 in 8-bit mode.
- R4: A read strobe to the data register clears all five status flags; a status read clears nothing.
- R5: Each bit is the majority of three samples at oversampling slots 7, 8 and 9 of the bit. If the samples disagree in any bit of an accepted frame, the noise flag is set and the data is still correct.
- R6: A stop bit whose majority is 0 sets the framing-error flag, and the word is still delivered.
- R7: If a frame completes while ready is still 1, overrun is set and the earlier data stays in the data register.
- R8: The idle flag is set once the line has stayed high for 16×N ticks (N = 10 or 11) after at least one frame was accepted while awake, and it is not set again until another frame is accepted.
- R9: While the sleep bit is 1 and the word does not wake the receiver, completed frames set none of ready, overrun, idle, noise or framing error.
- R10: In idle-line mode, hardware clears the sleep bit after 16×N ticks of continuous high line counted from the later of the sleep write and the last frame.
- R11: In address-mark mode, hardware clears the sleep bit when a word with its most significant bit set completes, and that word sets ready; idle time never wakes in this mode.
- R12: `irq` is 1 when (receive interrupt enable and (ready or overrun)) or (idle interrupt enable and idle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One pulse per oversampling slot (16 per bit) |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Write strobe, control register only |
| reg_rd | input | 1 | Read strobe; at address 2 it clears the flags |
| reg_wdata | input | 6 | Write data for the control register |
| reg_rdata | output | 9 | Combinational read data for `reg_addr` |
| irq | output | 1 | Combined receiver interrupt |
| rx_pin_input | output | 1 | Forces the pin to input while the receiver is enabled |

## Verification
A frame's flags and data are due two synchronizer stages, then the centre of the stop bit, then two register stages after the stop bit begins, so they settle inside the stop bit. The bench therefore samples four cycles after a full stop bit and never mid-frame. Idle flags and idle-line wake are due 16×N ticks after the line settles high. The bench brackets each with one sample well before that point, which must show no change, and one well after, which must show the change. Register reads are combinational, so the bench samples them one nanosecond after it drives the address, before the edge that acts on the strobe.

// File: rtl/sleep_uart_rx_pkg.sv
package sleep_uart_rx_pkg;
  localparam int unsigned WORD_W = 9;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  // Packed MSB first: en is bit 0.
  typedef struct packed {
    logic idle_ie;
    logic rx_ie;
    logic nine;
    logic addr_wake;
    logic sleep;
    logic en;
  } ctrl_t;

  // Packed MSB first: rdy is bit 0.
  typedef struct packed {
    logic ferr;
    logic noise;
    logic ovr;
    logic idle;
    logic rdy;
  } stat_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned STAT_W = $bits(stat_t);
endpackage

// File: rtl/sleep_uart_rx_sync.sv
module sleep_uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_uart_rx_vote.sv
module sleep_uart_rx_vote #(
  parameter int OSR  = 16,
  parameter int PH_W = $clog2(OSR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [PH_W-1:0] phase,
  input  logic            line,
  output logic            vote,
  output logic            noisy
);
  localparam logic [PH_W-1:0] P_A = PH_W'(OSR/2 - 1);
  localparam logic [PH_W-1:0] P_B = PH_W'(OSR/2);

  logic s_a, s_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_a <= 1'b1;
      s_b <= 1'b1;
    end else if (tick) begin
      if (phase == P_A) s_a <= line;
      if (phase == P_B) s_b <= line;
    end
  end

  // Third sample is the live line in the deciding slot.
  assign vote  = (s_a & s_b) | (s_a & line) | (s_b & line);
  assign noisy = (s_a != line) || (s_b != line);
endmodule

// File: rtl/sleep_uart_rx_frame.sv
module sleep_uart_rx_frame
  import sleep_uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              nine,
  input  logic              tick,
  input  logic              line,
  input  logic              run_restart,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o,
  output logic              noise_o,
  output logic              ferr_o,
  output logic              char_idle_o
);
  localparam int PH_W  = $clog2(OSR);
  localparam int RUN_W = $clog2(OSR * 11 + 1);
  localparam logic [PH_W-1:0] P_DEC  = PH_W'(OSR/2 + 1);
  localparam logic [PH_W-1:0] P_LAST = PH_W'(OSR - 1);

  rx_state_e         state_q;
  logic [PH_W-1:0]   phase_q;
  logic [3:0]        bitn_q;
  logic [WORD_W-1:0] shreg_q;
  logic              nacc_q;
  logic [RUN_W-1:0]  run_q;
  logic [RUN_W-1:0]  run_tgt;
  logic              vote, noisy, decide;
  logic [3:0]        last_bit;

  sleep_uart_rx_vote #(.OSR(OSR), .PH_W(PH_W)) u_vote (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .phase (phase_q),
    .line  (line),
    .vote  (vote),
    .noisy (noisy)
  );

  assign decide   = tick && (phase_q == P_DEC);
  assign last_bit = nine ? 4'd8 : 4'd7;
  assign run_tgt  = nine ? RUN_W'(OSR * 11) : RUN_W'(OSR * 10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      phase_q <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      nacc_q  <= 1'b0;
      done_o  <= 1'b0;
      noise_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!enable) begin
        state_q <= RX_IDLE;
        phase_q <= '0;
        bitn_q  <= '0;
        nacc_q  <= 1'b0;
      end else if (tick) begin
        phase_q <= (phase_q == P_LAST) ? '0 : phase_q + 1'b1;
        unique case (state_q)
          RX_IDLE: begin
            phase_q <= PH_W'(1);
            if (!line) begin
              state_q <= RX_START;
              nacc_q  <= 1'b0;
            end
          end
          RX_START: if (decide) begin
            if (vote) state_q <= RX_IDLE;
            else begin
              state_q <= RX_DATA;
              bitn_q  <= '0;
              nacc_q  <= noisy;
            end
          end
          RX_DATA: if (decide) begin
            shreg_q <= {vote, shreg_q[WORD_W-1:1]};
            nacc_q  <= nacc_q | noisy;
            if (bitn_q == last_bit) state_q <= RX_STOP;
            else                    bitn_q  <= bitn_q + 1'b1;
          end
          RX_STOP: if (decide) begin
            state_q <= RX_IDLE;
            done_o  <= 1'b1;
            ferr_o  <= !vote;
            noise_o <= nacc_q | noisy;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  // Run of continuous high line while no frame is in progress.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= '0;
      char_idle_o <= 1'b0;
    end else begin
      char_idle_o <= 1'b0;
      if (!enable || run_restart || state_q != RX_IDLE || !line) run_q <= '0;
      else if (tick && run_q < run_tgt) begin
        run_q <= run_q + 1'b1;
        if (run_q == run_tgt - 1'b1) char_idle_o <= 1'b1;
      end
    end
  end

  assign word_o = nine ? shreg_q : {1'b0, shreg_q[WORD_W-1:1]};
endmodule

// File: rtl/sleep_uart_rx.sv
module sleep_uart_rx
  import sleep_uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rx_line,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              irq,
  output logic              rx_pin_input
);
  ctrl_t             ctrl_q;
  stat_t             stat_q;
  logic [WORD_W-1:0] data_q;
  logic              seen_q;
  logic              line_s;
  logic              done, noise, ferr, char_idle;
  logic [WORD_W-1:0] word;
  logic              ctrl_wr, data_rd, msb, addr_hit, wake_hit, accept;

  sleep_uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx_line),
    .q     (line_s)
  );

  sleep_uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (ctrl_q.en),
    .nine        (ctrl_q.nine),
    .tick        (sample_tick),
    .line        (line_s),
    .run_restart (ctrl_wr),
    .done_o      (done),
    .word_o      (word),
    .noise_o     (noise),
    .ferr_o      (ferr),
    .char_idle_o (char_idle)
  );

  assign ctrl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign data_rd  = reg_rd && (reg_addr == A_DATA);
  assign msb      = ctrl_q.nine ? word[8] : word[7];
  assign addr_hit = ctrl_q.addr_wake && done && msb;
  assign wake_hit = ctrl_q.en && ctrl_q.sleep &&
                    (ctrl_q.addr_wake ? addr_hit : char_idle);
  assign accept   = ctrl_q.en && done && (!ctrl_q.sleep || addr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (ctrl_wr)  ctrl_q <= ctrl_t'(reg_wdata);
    else if (wake_hit) ctrl_q.sleep <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      data_q <= '0;
      seen_q <= 1'b0;
    end else if (!ctrl_q.en) begin
      stat_q <= '0;
      seen_q <= 1'b0;
    end else begin
      if (data_rd) stat_q <= '0;
      if (accept) begin
        seen_q <= 1'b1;
        if (stat_q.rdy && !data_rd) stat_q.ovr <= 1'b1;
        else begin
          stat_q.rdy   <= 1'b1;
          stat_q.noise <= noise;
          stat_q.ferr  <= ferr;
          data_q       <= word;
        end
      end
      if (char_idle && seen_q && !ctrl_q.sleep) begin
        stat_q.idle <= 1'b1;
        seen_q      <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = WORD_W'(ctrl_q);
      A_STAT:  reg_rdata = WORD_W'(stat_q);
      A_DATA:  reg_rdata = data_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = (ctrl_q.rx_ie && (stat_q.rdy || stat_q.ovr)) ||
               (ctrl_q.idle_ie && stat_q.idle);
  assign rx_pin_input = ctrl_q.en;
endmodule

// File: rtl/sleep_uart_rx_chk.sv
module sleep_uart_rx_chk
  import sleep_uart_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [CTRL_W-1:0] reg_wdata,
  input logic              pin,
  input logic              irq,
  input ctrl_t             ctrl,
  input stat_t             stat,
  input logic [WORD_W-1:0] data,
  input logic              done,
  input logic              char_idle
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

  p_flags_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !$past(ctrl.en)) |-> (stat == '0));

  p_pin_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (pin == $past(reg_wdata[0])));

  p_ovr_keeps_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat.ovr) |-> $stable(data));

  p_ready_awake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat.rdy) |-> ($past(done) && (!$past(ctrl.sleep) || $past(ctrl.addr_wake))));

  p_idle_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl.sleep) && !$past(ctrl_wr) && !$past(ctrl.addr_wake)) |-> $past(char_idle));

  p_addr_wake_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl.sleep) && !$past(ctrl_wr) && $past(ctrl.addr_wake)) |-> $past(done));

  p_irq_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.rx_ie && (stat.rdy || stat.ovr)) |-> irq);
endmodule

bind sleep_uart_rx sleep_uart_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pin       (rx_pin_input),
  .irq       (irq),
  .ctrl      (ctrl_q),
  .stat      (stat_q),
  .data      (data_q),
  .done      (done),
  .char_idle (char_idle)
);

// File: tb/sleep_uart_rx_tb.sv
module sleep_uart_rx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b1;
  logic       rx_line = 1'b1;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [5:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic       irq, rx_pin_input;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sleep_uart_rx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_tick  (sample_tick),
    .rx_line      (rx_line),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq          (irq),
    .rx_pin_input (rx_pin_input)
  );

  // {nine-bit mode, word}
  localparam logic [9:0] VECS [6] = '{
    {1'b0, 9'h0A5}, {1'b0, 9'h1FF}, {1'b1, 9'h1C3},
    {1'b1, 9'h000}, {1'b0, 9'h080}, {1'b1, 9'h155}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] v);
    @(negedge clk);
    reg_addr = 2'd0; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic rd_data(output int v);
    @(negedge clk);
    reg_addr = 2'd2; reg_rd = 1'b1;
    #1 v = int'(reg_rdata);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send(input bit nine, input logic [8:0] w, input int glitch, input bit stop_v);
    int nb;
    nb = nine ? 9 : 8;
    for (int i = 0; i < nb + 2; i++) begin
      logic b;
      if (i == 0)       b = 1'b0;
      else if (i <= nb) b = w[i-1];
      else              b = stop_v;
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        rx_line = (i == glitch && c == 8) ? ~b : b;
      end
    end
    @(negedge clk);
    rx_line = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    peek(2'd0, v); check("R1 ctrl reset", v, 0);
    peek(2'd1, v); check("R1 stat reset", v, 0);
    check("R2 pin reset", int'(rx_pin_input), 0);
    check("R12 irq reset", int'(irq), 0);

    // R1: disabled receiver ignores a frame
    send(1'b0, 9'h055, -1, 1'b1);
    peek(2'd1, v); check("R1 disabled stat", v, 0);
    peek(2'd2, v); check("R1 disabled data", v, 0);

    // R2
    wr_ctrl(6'h01);
    check("R2 pin enabled", int'(rx_pin_input), 1);

    // Vector table: R3, R4
    for (int k = 0; k < 6; k++) begin
      bit nine;
      logic [8:0] w;
      nine = VECS[k][9];
      w    = VECS[k][8:0];
      wr_ctrl({2'b00, nine, 3'b001});
      send(nine, w, -1, 1'b1);
      peek(2'd1, v); check("R3 ready", v, 1);
      peek(2'd1, v); check("R4 status read keeps", v, 1);
      rd_data(v); check("R3 data", v, nine ? int'(w) : int'(w[7:0]));
      peek(2'd1, v); check("R4 cleared", v, 0);
    end

    // R5: glitch on slot 8 of data bit 2
    wr_ctrl(6'h01);
    send(1'b0, 9'h03C, 3, 1'b1);
    peek(2'd1, v); check("R5 noise flag", v, 9);
    rd_data(v); check("R5 data", v, 'h3C);

    // R6: stop bit low
    send(1'b0, 9'h011, -1, 1'b0);
    repeat (20) @(negedge clk);
    peek(2'd1, v); check("R6 framing flag", v, 'h11);
    rd_data(v); check("R6 data", v, 'h11);

    // R7 and R12: overrun with receive interrupt
    wr_ctrl(6'h11);
    send(1'b0, 9'h021, -1, 1'b1);
    check("R12 irq on ready", int'(irq), 1);
    send(1'b0, 9'h042, -1, 1'b1);
    peek(2'd1, v); check("R7 overrun", v, 5);
    rd_data(v); check("R7 old data kept", v, 'h21);
    @(negedge clk);
    check("R12 irq cleared", int'(irq), 0);

    // R8 and R12: idle flag and idle interrupt
    wr_ctrl(6'h21);
    send(1'b0, 9'h066, -1, 1'b1);
    rd_data(v);
    repeat (90) @(negedge clk);
    peek(2'd1, v); check("R8 idle early", v, 0);
    repeat (110) @(negedge clk);
    peek(2'd1, v); check("R8 idle set", v, 2);
    check("R12 idle irq", int'(irq), 1);
    rd_data(v);
    repeat (250) @(negedge clk);
    peek(2'd1, v); check("R8 idle not repeated", v, 0);

    // R9 and R10: idle-line wake
    wr_ctrl(6'h03);
    send(1'b0, 9'h012, -1, 1'b1);
    peek(2'd1, v); check("R9 asleep no flags", v, 0);
    repeat (100) @(negedge clk);
    peek(2'd0, v); check("R10 still asleep", v, 3);
    repeat (120) @(negedge clk);
    peek(2'd0, v); check("R10 woken", v, 1);
    peek(2'd1, v); check("R9 no idle after wake", v, 0);

    // R11: address-mark wake, 8-bit
    wr_ctrl(6'h07);
    send(1'b0, 9'h005, -1, 1'b1);
    peek(2'd1, v); check("R9 addr asleep flags", v, 0);
    repeat (250) @(negedge clk);
    peek(2'd0, v); check("R11 idle does not wake", v, 7);
    send(1'b0, 9'h085, -1, 1'b1);
    peek(2'd0, v); check("R11 woken", v, 5);
    peek(2'd1, v); check("R11 ready", v, 1);
    rd_data(v); check("R11 data", v, 'h85);

    // R11: address-mark wake, 9-bit
    wr_ctrl(6'h0F);
    send(1'b1, 9'h0FF, -1, 1'b1);
    peek(2'd0, v); check("R11 nine stays asleep", v, 'h0F);
    send(1'b1, 9'h100, -1, 1'b1);
    peek(2'd0, v); check("R11 nine woken", v, 'h0D);
    rd_data(v); check("R11 nine data", v, 'h100);

    // R1: disable clears pending flags
    wr_ctrl(6'h01);
    send(1'b0, 9'h0AA, -1, 1'b1);
    peek(2'd1, v); check("R1 ready before disable", v, 1);
    wr_ctrl(6'h00);
    peek(2'd1, v); check("R1 disable clears", v, 0);
    check("R2 pin released", int'(rx_pin_input), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule